// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer

This block is the cycle-level control core of a converter that samples two channels at the same instant and converts them one after the other. A falling edge on the active-low start input moves the sampler from acquisition into hold. Two channel conversions then run back to back, each for a fixed number of clock cycles. A busy output covers the whole pair. An active-low end-of-conversion output pulses once near the end of each channel. The analog front end and the conversion arithmetic are replaced by counters and by result values injected on two input buses.

Channel A's result is captured when its conversion ends. Both results are then committed together into the output register on the cycle busy drops, so the falling edge of busy serves as the data-ready strobe. After each pair an acquisition window runs before the next start is accepted. In impulse mode, a start input still held low at the end of that window launches the next pair with no new edge. A power-down input lets the pair in progress finish and then blocks further starts. A synchronous abort input cancels any conversion and sends the block back to acquisition.

Top module: `dual_conv_seq`

## Requirements
- R1: When the block is ready (acquisition done, not busy) and `pwr_down_i` is low, a high-to-low change of `start_ni` seen at a clock edge raises `busy_o` from that edge on.
- R2: Without an abort, `busy_o` stays high for exactly 2*CONV_CYC clock cycles per start.
- R3: On the edge where `busy_o` falls, `data_o` loads {channel A result, channel B result}. Channel A sits in bits [2*DATA_W-1:DATA_W] and is the `res_a_i` value present on the last cycle of the first conversion. Channel B sits in bits [DATA_W-1:0] and is the `res_b_i` value present on the last cycle of the second conversion. At every other edge `data_o` holds its value.
- R4: `eoc_no` is low for EOC_CYC cycles at the end of each channel conversion. This gives two separate low pulses, 2*EOC_CYC low cycles in total, per busy period. `eoc_no` is high whenever `busy_o` is low.
- R5: After each pair, an acquisition window of ACQ_CYC cycles runs. Start edges during this window are ignored and `busy_o` stays low.
- R6: A start edge that arrives while `busy_o` is high is ignored. It adds no conversion and does not lengthen the busy period.
- R7: With `impulse_i` high, if `start_ni` is low on the last acquisition cycle, `busy_o` rises again exactly ACQ_CYC cycles after it fell. With `impulse_i` low, a level held low does not start a conversion.
- R8: Raising `pwr_down_i` during a conversion does not stop it, and its result is committed. While `pwr_down_i` is high, no new conversion starts.
- R9: When `abort_i` is high at an edge, `busy_o` is low and `eoc_no` is high after that edge and `data_o` is unchanged. The block then re-acquires for ACQ_CYC cycles before it accepts a start.
- R10: After `rst_ni` is asserted, `busy_o` is 0, `eoc_no` is 1 and `data_o` is 0. The block begins in acquisition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Synchronous abort of any conversion |
| start_ni | input | 1 | Active-low conversion start, already synchronous to clk_i |
| impulse_i | input | 1 | Auto-start when start is still low at the end of acquisition |
| pwr_down_i | input | 1 | Inhibit new conversions, finish the current one |
| res_a_i | input | DATA_W | Injected channel A result |
| res_b_i | input | DATA_W | Injected channel B result |
| busy_o | output | 1 | High while the two-channel conversion is running |
| eoc_no | output | 1 | Active-low end-of-conversion pulse per channel |
| data_o | output | 2*DATA_W | Committed result pair, channel A in the upper half |

## Verification
The assertions assume that every input is synchronous to the clock, that `start_ni` needs no further synchronizing, and that EOC_CYC is at least 1 and less than CONV_CYC. Without that last condition the two end-of-conversion pulses would merge. The stimulus changes inputs only on the falling clock edge and holds `abort_i` high for a single cycle. It uses parameter values that keep both pulses separate. The edge cases are pushed into this window on purpose: start edges placed inside busy and inside acquisition, a start level held across the end of acquisition with impulse mode on and off, power-down raised mid-pair, and an abort placed inside the second channel's end-of-conversion pulse.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    ST_ACQ    = 2'd0,
    ST_READY  = 2'd1,
    ST_CONV_A = 2'd2,
    ST_CONV_B = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dcs_fall_det.sv
module dcs_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/dcs_seq_fsm.sv
module dcs_seq_fsm
  import dcs_pkg::*;
#(
  parameter int ACQ_CYC  = 6,
  parameter int CONV_CYC = 10,
  parameter int EOC_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic start_fall_i,
  input  logic start_lvl_ni,
  input  logic impulse_i,
  input  logic pwr_down_i,
  output logic busy_o,
  output logic eoc_no,
  output logic cap_a_o,
  output logic commit_o
);
  localparam int CNT_MAX = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] EOC_FROM  = CNT_W'(CONV_CYC - EOC_CYC);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_conv, conv_last, acq_done, go;

  assign in_conv   = (state_q == ST_CONV_A) || (state_q == ST_CONV_B);
  assign conv_last = in_conv && (cnt_q == CONV_LAST);
  assign acq_done  = (state_q == ST_ACQ) && (cnt_q == ACQ_LAST);
  // edge start when ready, level start at acquisition end in impulse mode
  assign go = !pwr_down_i &&
              (((state_q == ST_READY) && start_fall_i) ||
               (acq_done && impulse_i && !start_lvl_ni));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      ST_ACQ: if (acq_done) begin
        state_d = go ? ST_CONV_A : ST_READY;
        cnt_d   = '0;
      end
      ST_READY: begin
        cnt_d = '0;
        if (go) state_d = ST_CONV_A;
      end
      ST_CONV_A: if (conv_last) begin
        state_d = ST_CONV_B;
        cnt_d   = '0;
      end
      ST_CONV_B: if (conv_last) begin
        state_d = ST_ACQ;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_ACQ;
        cnt_d   = '0;
      end
    endcase
    if (abort_i) begin
      state_d = ST_ACQ;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACQ;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o   = in_conv;
  assign eoc_no   = ~(in_conv && (cnt_q >= EOC_FROM));
  assign cap_a_o  = (state_q == ST_CONV_A) && conv_last && !abort_i;
  assign commit_o = (state_q == ST_CONV_B) && conv_last && !abort_i;

  // R1
  start_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY && start_fall_i && !pwr_down_i && !abort_i) |=> busy_o);
  // R2
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o);
  // R4
  eoc_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_no |-> busy_o);
  // R5
  acq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACQ && cnt_q != ACQ_LAST && !abort_i) |=> !busy_o);
  // R7
  impulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq_done && impulse_i && !start_lvl_ni && !pwr_down_i && !abort_i) |=> busy_o);
  // R8
  pd_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_down_i && !busy_o) |=> !busy_o);
  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && eoc_no));
endmodule

// File: rtl/dcs_result_reg.sv
module dcs_result_reg #(
  parameter int DATA_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_a_i,
  input  logic                  commit_i,
  input  logic [DATA_W-1:0]     res_a_i,
  input  logic [DATA_W-1:0]     res_b_i,
  output logic [2*DATA_W-1:0]   data_o
);
  logic [DATA_W-1:0] hold_a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_a_q <= '0;
      data_o   <= '0;
    end else begin
      if (cap_a_i)  hold_a_q <= res_a_i;
      if (commit_i) data_o   <= {hold_a_q, res_b_i};
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(data_o));
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq #(
  parameter int DATA_W   = 16,
  parameter int ACQ_CYC  = 6,
  parameter int CONV_CYC = 10,
  parameter int EOC_CYC  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                abort_i,
  input  logic                start_ni,
  input  logic                impulse_i,
  input  logic                pwr_down_i,
  input  logic [DATA_W-1:0]   res_a_i,
  input  logic [DATA_W-1:0]   res_b_i,
  output logic                busy_o,
  output logic                eoc_no,
  output logic [2*DATA_W-1:0] data_o
);
  logic start_fall, cap_a, commit;

  dcs_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (start_ni),
    .fall_o (start_fall)
  );

  dcs_seq_fsm #(
    .ACQ_CYC  (ACQ_CYC),
    .CONV_CYC (CONV_CYC),
    .EOC_CYC  (EOC_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_i      (abort_i),
    .start_fall_i (start_fall),
    .start_lvl_ni (start_ni),
    .impulse_i    (impulse_i),
    .pwr_down_i   (pwr_down_i),
    .busy_o       (busy_o),
    .eoc_no       (eoc_no),
    .cap_a_o      (cap_a),
    .commit_o     (commit)
  );

  dcs_result_reg #(
    .DATA_W (DATA_W)
  ) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_a_i  (cap_a),
    .commit_i (commit),
    .res_a_i  (res_a_i),
    .res_b_i  (res_b_i),
    .data_o   (data_o)
  );
endmodule

// File: tb/dual_conv_seq_test.sv
module dual_conv_seq_test;
  localparam int W = 16;
  localparam int ACQ = 6;
  localparam int CV = 10;
  localparam int EC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort = 1'b0, start_n = 1'b1, impulse = 1'b0, pd = 1'b0;
  logic [W-1:0] res_a = '0, res_b = '0;
  logic busy, eoc_n;
  logic [2*W-1:0] data;

  always #10 clk = ~clk;

  dual_conv_seq #(.DATA_W(W), .ACQ_CYC(ACQ), .CONV_CYC(CV), .EOC_CYC(EC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .start_ni(start_n),
    .impulse_i(impulse), .pwr_down_i(pd), .res_a_i(res_a), .res_b_i(res_b),
    .busy_o(busy), .eoc_no(eoc_n), .data_o(data)
  );

  int checks = 0, fails = 0;
  logic [2*W-1:0] exp_q[$];
  logic [2*W-1:0] last_good = '0;
  bit mon_on = 1'b0, abort_pending = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
  endtask

  // driver: launch a pair and push the expected result
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input bit hold);
    res_a = a; res_b = b; start_n = 1'b0;
    exp_q.push_back({a, b});
    tick(1);
    check(busy === 1'b1, "R1 busy after start edge", busy, 1);
    tick(1);
    if (!hold) start_n = 1'b1;
    tick(CV);
    res_a = ~a;  // after channel A capture: must not reach data_o (R3)
  endtask

  // monitor / scoreboard
  bit busy_p = 1'b0, eoc_p = 1'b1;
  int blen = 0, elow = 0, epul = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) begin
        if (!busy_p) begin blen = 0; elow = 0; epul = 0; end
        blen++;
        if (!eoc_n) begin
          elow++;
          if (eoc_p) epul++;
        end
      end else begin
        check(eoc_n === 1'b1, "R4 eoc high while idle", eoc_n, 1);
        if (busy_p) begin
          if (abort_pending) abort_pending = 1'b0;
          else begin
            check(blen == 2*CV, "R2 busy length", blen, 2*CV);
            check(epul == 2, "R4 eoc pulse count", epul, 2);
            check(elow == 2*EC, "R4 eoc low cycles", elow, 2*EC);
            if (exp_q.size() == 0) check(1'b0, "R3 unexpected result", data, 0);
            else begin
              logic [2*W-1:0] e;
              e = exp_q.pop_front();
              check(data === e, "R3 committed pair", data, e);
              last_good = e;
            end
          end
        end
      end
      busy_p = busy;
      eoc_p = eoc_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
      report();
      $finish;
    end
  end

  initial begin
    bit seen;
    int gap;
    tick(2);
    check(busy === 1'b0, "R10 busy reset", busy, 0);
    check(eoc_n === 1'b1, "R10 eoc reset", eoc_n, 1);
    check(data === '0, "R10 data reset", data, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tick(ACQ + 3);

    // basic pairs
    launch(16'h1234, 16'hABCD, 1'b0); wait_idle(); tick(ACQ + 2);
    launch(16'hFFFF, 16'h0000, 1'b0); wait_idle(); tick(ACQ + 2);

    // R6: edge during busy
    res_a = 16'h0F0F; res_b = 16'hF0F0; start_n = 1'b0;
    exp_q.push_back({16'h0F0F, 16'hF0F0});
    tick(2); start_n = 1'b1; tick(3); start_n = 1'b0; tick(1); start_n = 1'b1;
    wait_idle(); tick(ACQ + 3);
    check(busy === 1'b0, "R6 no extra pair after busy edge", busy, 0);

    // R5: edge during acquisition
    launch(16'h5555, 16'hAAAA, 1'b0); wait_idle();
    tick(1); start_n = 1'b0; tick(1); start_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < ACQ + 3; i++) begin tick(1); seen |= busy; end
    check(seen == 1'b0, "R5 acquisition edge ignored", seen, 0);

    // R7: impulse auto-start
    impulse = 1'b1;
    launch(16'h0001, 16'h8000, 1'b1);
    exp_q.push_back({16'h0001, 16'h8000});
    res_a = 16'h0001;
    wait_idle();
    gap = 0;
    while (!busy && gap < 50) begin tick(1); gap++; end
    check(gap == ACQ, "R7 impulse restart gap", gap, ACQ);
    start_n = 1'b1;
    wait_idle(); tick(ACQ + 3);
    check(busy === 1'b0, "R7 no restart with start high", busy, 0);

    // R7: level held with impulse off
    impulse = 1'b0;
    launch(16'h2222, 16'h3333, 1'b1); wait_idle(); tick(ACQ + 4);
    check(busy === 1'b0, "R7 level ignored without impulse", busy, 0);
    start_n = 1'b1; tick(2);

    // R8: power-down mid conversion
    res_a = 16'h7E7E; res_b = 16'h1111; start_n = 1'b0;
    exp_q.push_back({16'h7E7E, 16'h1111});
    tick(2); start_n = 1'b1; pd = 1'b1;
    wait_idle();
    check(data === {16'h7E7E, 16'h1111}, "R8 pair completes under power-down", data, {16'h7E7E, 16'h1111});
    tick(ACQ + 2);
    start_n = 1'b0; tick(1); start_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(1); seen |= busy; end
    check(seen == 1'b0, "R8 start blocked in power-down", seen, 0);
    pd = 1'b0; tick(2);
    launch(16'h4444, 16'h5A5A, 1'b0); wait_idle(); tick(ACQ + 2);

    // R9: abort inside channel B end-of-conversion pulse
    res_a = 16'hDEAD; res_b = 16'hBEEF; start_n = 1'b0;
    tick(2); start_n = 1'b1; tick(2*CV - 3);
    check(eoc_n === 1'b0, "R4 eoc low before abort", eoc_n, 0);
    abort_pending = 1'b1; abort = 1'b1;
    tick(1); abort = 1'b0;
    check(busy === 1'b0, "R9 busy cleared by abort", busy, 0);
    check(eoc_n === 1'b1, "R9 eoc released by abort", eoc_n, 1);
    check(data === last_good, "R9 data kept after abort", data, last_good);
    tick(1); start_n = 1'b0; tick(1); start_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < ACQ; i++) begin tick(1); seen |= busy; end
    check(seen == 1'b0, "R9 re-acquire after abort", seen, 0);
    tick(2);
    launch(16'hC0DE, 16'h0BAD, 1'b0); wait_idle(); tick(3);

    check(exp_q.size() == 0, "R3 all expected pairs seen", exp_q.size(), 0);
    done = 1'b1;
    report();
    $finish;
  end
endmodule